// File: doc/BRIEF.md
# Internal-Clock Multichannel Scan Sequencer

This block takes over once a converter command word has been fully received and decoded. It turns the scan field and the requested top channel into an ordered list of channels. For each entry it runs one acquire-and-convert step, paced by an internal-clock enable (`tickEn`). It pulses a sample strobe at the end of acquisition and stores the 16-bit result returned by a converter stub in a small result buffer.

`eocN` stays high while the list is running. It falls once, after the result of the last list entry has been stored. From then on the host reads the stored results on its own serial clock, in the order they were converted and MSB first. Extra host clocks wrap around to the start of the buffer instead of producing zeros.

A rising chip select abandons whatever is in progress and returns the block to idle. A fresh command restarts the block from any state.

Top module: `scan_seq`

## Requirements
- R1: Scan code 2'b00 converts channel N (`cmdChan`) exactly once.
- R2: Scan code 2'b01 converts channels 0, 1, ... N, one each, in ascending order.
- R3: Scan code 2'b10 converts channels NUM_CH/2 up to N in ascending order. When N is below NUM_CH/2, it converts channel N once.
- R4: Scan code 2'b11 converts channel N NUM_CH times in a row.
- R5: With `cmdIntClk` low, the scan code is ignored and channel N is converted once.
- R6: The first tick of `tickEn` after the `cmdValid` cycle counts as tick 1 of the first conversion. `sampleStb` is high for one cycle right after the 6th tick of a conversion when `cmdWide` is 0, and right after the 18th tick when it is 1.
- R7: Each conversion occupies 25 ticks (`cmdWide`=0) or 32 ticks (`cmdWide`=1). Sample k (counting from 0) therefore follows tick acq + k·conv.
- R8: `eocN` is high after reset and while the list runs. It falls only after results for all list entries have been captured.
- R9: When `eocN` is low, `dout` carries bit 15 of the first result. Each falling edge of `sclk` advances one bit, MSB first, through the results in conversion order.
- R10: After the last bit of the last stored result, the next `sclk` falling edge presents bit 15 of the first result again.
- R11: `csN` high in mid-sequence aborts the sequence. No further `sampleStb` pulses follow, and `eocN` stays high.
- R12: `eocN` returns high in the cycle after `csN` rises, or after a new `cmdValid` is accepted.
- R13: `dout` is 0 whenever no completed result set is being read out (`eocN` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select; high aborts and idles |
| sclk | input | 1 | Host serial clock, sampled on clk; falling edge advances readout |
| cmdValid | input | 1 | One-cycle pulse: decoded command fields are valid, start a list |
| cmdChan | input | $clog2(NUM_CH) | Requested channel N |
| cmdScan | input | 2 | Scan code |
| cmdIntClk | input | 1 | 1 = internal clock mode (scanning allowed) |
| cmdWide | input | 1 | 1 = 16-bit framing timing, 0 = 8-bit framing timing |
| tickEn | input | 1 | Internal-clock enable, one cycle per internal clock |
| resValid | input | 1 | Converter stub: result available |
| resData | input | RES_W | Converter stub result |
| chanSel | output | $clog2(NUM_CH) | Channel of the current conversion (binary) |
| sampleStb | output | 1 | One-cycle sample strobe at end of acquisition |
| eocN | output | 1 | Active-low end of sequence |
| dout | output | 1 | Serial result data |

## Verification
The bench builds two copies side by side: one with NUM_CH=8 and one with NUM_CH=4. Both receive every command and use the default tick counts. The 4-channel copy brings the shifted start of code 2'b10 (channel 2 instead of 4) and the four-fold repeat of code 2'b11 within reach. It also covers a result buffer whose wrap point differs from the 8-channel copy on the same host clock stream. Both framing timings are run, so that sample positions 6/18 and conversion lengths 25/32 are each checked against tick stamps.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  localparam int PTR_W = 4;
  localparam int LEN_W = 5;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} seq_state_e;

  typedef struct packed {
    logic             clear;
    logic [LEN_W-1:0] loadLen;
    logic             wrEn;
    logic [PTR_W-1:0] wrIdx;
    logic             readEn;
  } dp_ctl_t;
endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int NUM_CH            = 8,
  parameter int ACQ_TICKS_NARROW  = 6,
  parameter int ACQ_TICKS_WIDE    = 18,
  parameter int CONV_TICKS_NARROW = 25,
  parameter int CONV_TICKS_WIDE   = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      csN,
  input  logic                      cmdValid,
  input  logic [$clog2(NUM_CH)-1:0] cmdChan,
  input  logic [1:0]                cmdScan,
  input  logic                      cmdIntClk,
  input  logic                      cmdWide,
  input  logic                      tickEn,
  input  logic                      resValid,
  output logic [$clog2(NUM_CH)-1:0] chanSel,
  output logic                      sampleStb,
  output logic                      eocN,
  output dp_ctl_t                   dpCtl
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam int MAXT = (CONV_TICKS_WIDE > CONV_TICKS_NARROW) ? CONV_TICKS_WIDE : CONV_TICKS_NARROW;
  localparam int TW   = $clog2(MAXT);
  localparam logic [PTR_W-1:0] HALF_CH = PTR_W'(NUM_CH / 2);

  seq_state_e       state;
  logic [PTR_W-1:0] pos, base;
  logic [LEN_W-1:0] len;
  logic             rep, wideQ, sampled, resGot;
  logic [TW-1:0]    tickCnt, acqLast, convLast;

  logic [PTR_W-1:0] cmdN, decBase, chanSum;
  logic [LEN_W-1:0] decLen;
  logic             decRep, start, lastPos, captureOk;

  assign cmdN = {{(PTR_W-CH_W){1'b0}}, cmdChan};
  assign start = cmdValid && !csN;

  // scan-list decode from the incoming command fields
  always_comb begin
    decBase = cmdN;
    decLen  = LEN_W'(1);
    decRep  = 1'b1;
    if (cmdIntClk) begin
      case (cmdScan)
        2'b01: begin
          decBase = '0;
          decLen  = LEN_W'(cmdN) + LEN_W'(1);
          decRep  = 1'b0;
        end
        2'b10: begin
          if (cmdN >= HALF_CH) begin
            decBase = HALF_CH;
            decLen  = LEN_W'(cmdN - HALF_CH) + LEN_W'(1);
            decRep  = 1'b0;
          end
        end
        2'b11: decLen = LEN_W'(NUM_CH);
        default: ;
      endcase
    end
  end

  assign acqLast  = wideQ ? TW'(ACQ_TICKS_WIDE - 1)  : TW'(ACQ_TICKS_NARROW - 1);
  assign convLast = wideQ ? TW'(CONV_TICKS_WIDE - 1) : TW'(CONV_TICKS_NARROW - 1);
  assign lastPos  = ({1'b0, pos} + LEN_W'(1)) == len;
  assign captureOk = (state == S_RUN) && resValid && sampled && !resGot && !csN && !cmdValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      pos       <= '0;
      base      <= '0;
      len       <= '0;
      rep       <= 1'b0;
      wideQ     <= 1'b0;
      sampled   <= 1'b0;
      resGot    <= 1'b0;
      tickCnt   <= '0;
      sampleStb <= 1'b0;
    end else if (csN) begin
      state     <= S_IDLE;
      sampleStb <= 1'b0;
    end else if (cmdValid) begin
      state     <= S_RUN;
      pos       <= '0;
      base      <= decBase;
      len       <= decLen;
      rep       <= decRep;
      wideQ     <= cmdWide;
      sampled   <= 1'b0;
      resGot    <= 1'b0;
      tickCnt   <= '0;
      sampleStb <= 1'b0;
    end else if (state == S_RUN) begin
      sampleStb <= 1'b0;
      if (captureOk) resGot <= 1'b1;
      if (tickEn) begin
        if (tickCnt == acqLast) begin
          sampleStb <= 1'b1;
          sampled   <= 1'b1;
        end
        if (tickCnt == convLast) begin
          if (resGot) begin
            if (lastPos) state <= S_DONE;
            else begin
              pos     <= pos + PTR_W'(1);
              tickCnt <= '0;
              sampled <= 1'b0;
              resGot  <= 1'b0;
            end
          end
        end else begin
          tickCnt <= tickCnt + TW'(1);
        end
      end
    end
  end

  assign chanSum = base + pos;
  assign chanSel = rep ? base[CH_W-1:0] : chanSum[CH_W-1:0];
  assign eocN    = (state != S_DONE);

  assign dpCtl.clear   = start;
  assign dpCtl.loadLen = decLen;
  assign dpCtl.wrEn    = captureOk;
  assign dpCtl.wrIdx   = pos;
  assign dpCtl.readEn  = (state == S_DONE);

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (state == S_IDLE && eocN)); // R11
  AST_STB_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> ($past(state) == S_RUN)); // R6
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN) |-> ({1'b0, pos} < len)); // R2
  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN) |-> (tickCnt <= convLast)); // R7
  AST_EOC_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eocN) |-> ($past(state) == S_RUN && $past(resGot))); // R8
endmodule

// File: rtl/scan_seq_dp.sv
module scan_seq_dp
  import scan_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclk,
  input  dp_ctl_t          dpCtl,
  input  logic [RES_W-1:0] resData,
  output logic             dout
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int BIT_W = $clog2(RES_W);
  localparam int BP_W  = CH_W + BIT_W;

  logic [RES_W-1:0] rdWords [NUM_CH];
  logic [LEN_W-1:0] cnt;
  logic [BP_W-1:0]  bitPtr, lastBit;
  logic             sclkQ, sclkFall;
  logic [CH_W-1:0]  wordIdx;
  logic [BIT_W-1:0] bitInWord;

  for (genvar e = 0; e < NUM_CH; e++) begin : g_entry
    logic [RES_W-1:0] word;
    always_ff @(posedge clk) begin
      if (dpCtl.wrEn && dpCtl.wrIdx == PTR_W'(e)) word <= resData;
    end
    assign rdWords[e] = word;
  end

  assign sclkFall = sclkQ && !sclk;
  assign lastBit  = BP_W'(int'(cnt) * RES_W - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ  <= 1'b0;
      cnt    <= '0;
      bitPtr <= '0;
    end else begin
      sclkQ <= sclk;
      if (dpCtl.clear) begin
        cnt    <= dpCtl.loadLen;
        bitPtr <= '0;
      end else if (dpCtl.readEn && sclkFall) begin
        bitPtr <= (bitPtr == lastBit) ? '0 : bitPtr + BP_W'(1);
      end
    end
  end

  assign wordIdx   = bitPtr[BP_W-1:BIT_W];
  assign bitInWord = bitPtr[BIT_W-1:0];
  assign dout      = dpCtl.readEn ? rdWords[wordIdx][~bitInWord] : 1'b0;

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtl.readEn |-> !dout); // R13
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.readEn && $past(dpCtl.readEn) && $past(sclkFall) && $past(bitPtr) == $past(lastBit))
    |-> (bitPtr == '0)); // R10
  AST_CNT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.readEn |-> (cnt != '0 && int'(cnt) <= NUM_CH)); // R8
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_seq_pkg::*;
#(
  parameter int NUM_CH            = 8,
  parameter int RES_W             = 16,
  parameter int ACQ_TICKS_NARROW  = 6,
  parameter int ACQ_TICKS_WIDE    = 18,
  parameter int CONV_TICKS_NARROW = 25,
  parameter int CONV_TICKS_WIDE   = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      csN,
  input  logic                      sclk,
  input  logic                      cmdValid,
  input  logic [$clog2(NUM_CH)-1:0] cmdChan,
  input  logic [1:0]                cmdScan,
  input  logic                      cmdIntClk,
  input  logic                      cmdWide,
  input  logic                      tickEn,
  input  logic                      resValid,
  input  logic [RES_W-1:0]          resData,
  output logic [$clog2(NUM_CH)-1:0] chanSel,
  output logic                      sampleStb,
  output logic                      eocN,
  output logic                      dout
);
  dp_ctl_t dpCtl;

  scan_seq_ctrl #(
    .NUM_CH(NUM_CH), .ACQ_TICKS_NARROW(ACQ_TICKS_NARROW), .ACQ_TICKS_WIDE(ACQ_TICKS_WIDE),
    .CONV_TICKS_NARROW(CONV_TICKS_NARROW), .CONV_TICKS_WIDE(CONV_TICKS_WIDE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .cmdValid(cmdValid), .cmdChan(cmdChan),
    .cmdScan(cmdScan), .cmdIntClk(cmdIntClk), .cmdWide(cmdWide), .tickEn(tickEn),
    .resValid(resValid), .chanSel(chanSel), .sampleStb(sampleStb), .eocN(eocN),
    .dpCtl(dpCtl)
  );

  scan_seq_dp #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclk(sclk), .dpCtl(dpCtl), .resData(resData), .dout(dout)
  );
endmodule

// File: tb/scan_seq_tb.sv
module scan_seq_tb;
  localparam int CLK_PERIOD = 10;

  // {scan[1:0], n[2:0], intClk, wide}
  localparam logic [6:0] VEC [7] = '{
    {2'b00, 3'd3, 1'b1, 1'b0},
    {2'b01, 3'd5, 1'b1, 1'b0},
    {2'b10, 3'd6, 1'b1, 1'b1},
    {2'b10, 3'd3, 1'b1, 1'b0},
    {2'b11, 3'd2, 1'b1, 1'b0},
    {2'b01, 3'd7, 1'b0, 1'b1},
    {2'b01, 3'd7, 1'b1, 1'b1}
  };

  logic clk = 0, rstN = 0, csN = 1, sclk = 0;
  logic cmdValid = 0, cmdIntClk = 0, cmdWide = 0, tickEn = 0;
  logic [2:0] cmdChan = 0;
  logic [1:0] cmdScan = 0;
  logic resValid8 = 0, resValid4 = 0;
  logic [15:0] resData8 = 0, resData4 = 0;
  logic [2:0] chanSel8;
  logic [1:0] chanSel4;
  logic sampleStb8, sampleStb4, eocN8, eocN4, dout8, dout4;

  int checks = 0, failures = 0;
  int n8 = 0, n4 = 0, tickCount = 0;
  int chLog8 [16], chLog4 [16], tickLog8 [16], tickLog4 [16];
  int expCh8 [16], expCh4 [16];
  int len8, len4;
  logic cmdReq = 0, pend8 = 0, pend4 = 0, tickPhase = 0;
  logic [15:0] pendData8 = 0, pendData4 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_seq #(.NUM_CH(8)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .cmdValid(cmdValid), .cmdChan(cmdChan),
    .cmdScan(cmdScan), .cmdIntClk(cmdIntClk), .cmdWide(cmdWide), .tickEn(tickEn),
    .resValid(resValid8), .resData(resData8), .chanSel(chanSel8), .sampleStb(sampleStb8),
    .eocN(eocN8), .dout(dout8));

  scan_seq #(.NUM_CH(4)) u_dut4 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .cmdValid(cmdValid), .cmdChan(cmdChan[1:0]),
    .cmdScan(cmdScan), .cmdIntClk(cmdIntClk), .cmdWide(cmdWide), .tickEn(tickEn),
    .resValid(resValid4), .resData(resData4), .chanSel(chanSel4), .sampleStb(sampleStb4),
    .eocN(eocN4), .dout(dout4));

  // converter stubs, tick source and command pulse, all on the falling clock edge
  always @(negedge clk) begin
    resValid8 = pend8; resData8 = pendData8; pend8 = 0;
    resValid4 = pend4; resData4 = pendData4; pend4 = 0;
    if (sampleStb8) begin
      if (n8 < 16) begin chLog8[n8] = int'(chanSel8); tickLog8[n8] = tickCount; end
      pendData8 = {4'hA, 1'b0, chanSel8, 8'(n8)}; pend8 = 1; n8++;
    end
    if (sampleStb4) begin
      if (n4 < 16) begin chLog4[n4] = int'(chanSel4); tickLog4[n4] = tickCount; end
      pendData4 = {4'h5, 2'b00, chanSel4, 8'(n4)}; pend4 = 1; n4++;
    end
    if (cmdReq) begin
      cmdValid = 1; cmdReq = 0; tickCount = 0; n8 = 0; n4 = 0; tickEn = 0; tickPhase = 0;
    end else begin
      cmdValid = 0; tickPhase = ~tickPhase; tickEn = tickPhase;
      if (tickEn) tickCount++;
    end
  end

  task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected channel list straight from the scan-code rules
  task automatic calcList(input int numCh, input int code, input int n, input int intm,
                          output int len, output int chs [16]);
    int half = numCh / 2;
    len = 1; chs[0] = n;
    if (intm != 0) begin
      if (code == 1) begin len = n + 1; for (int i = 0; i <= n; i++) chs[i] = i; end
      else if (code == 2 && n >= half) begin
        len = n - half + 1; for (int i = 0; i < len; i++) chs[i] = half + i;
      end
      else if (code == 3) begin len = numCh; for (int i = 0; i < numCh; i++) chs[i] = n; end
    end
  endtask

  task automatic issue(input logic [6:0] v);
    cmdScan = v[6:5]; cmdChan = v[4:2]; cmdIntClk = v[1]; cmdWide = v[0];
    @(posedge clk); cmdReq = 1;
    @(negedge clk); @(negedge clk);
    chk(eocN8 && eocN4, "R12", "eocN high after new command", int'(eocN8 & eocN4), 1);
  endtask

  task automatic waitDone(output logic ok);
    ok = 0;
    for (int c = 0; c < 4000; c++) begin
      if (!eocN8 && !eocN4) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  function automatic logic [15:0] word8(input int k);
    return {4'hA, 1'b0, 3'(expCh8[k]), 8'(k)};
  endfunction
  function automatic logic [15:0] word4(input int k);
    return {4'h5, 2'b00, 2'(expCh4[k]), 8'(k)};
  endfunction

  task automatic runVec(input logic [6:0] v);
    logic ok;
    int acq, conv, tot8, tot4, nb;
    calcList(8, int'(v[6:5]), int'(v[4:2]), int'(v[1]), len8, expCh8);
    calcList(4, int'(v[6:5]), int'(v[3:2]), int'(v[1]), len4, expCh4);
    acq  = v[0] ? 18 : 6;
    conv = v[0] ? 32 : 25;
    issue(v);
    waitDone(ok);
    chk(ok, "R8", "eocN fell", int'(ok), 1);
    chk(n8 == len8, "R8", "dut8 conversions before eocN fell", n8, len8);
    chk(n4 == len4, "R8", "dut4 conversions before eocN fell", n4, len4);
    for (int k = 0; k < len8 && k < n8; k++) begin
      chk(chLog8[k] == expCh8[k], "R1 R2 R3 R4 R5", "dut8 channel order", chLog8[k], expCh8[k]);
      chk(tickLog8[k] == acq + k * conv, k == 0 ? "R6" : "R7", "dut8 sample tick", tickLog8[k], acq + k * conv);
    end
    for (int k = 0; k < len4 && k < n4; k++) begin
      chk(chLog4[k] == expCh4[k], "R1 R2 R3 R4 R5", "dut4 channel order", chLog4[k], expCh4[k]);
      chk(tickLog4[k] == acq + k * conv, k == 0 ? "R6" : "R7", "dut4 sample tick", tickLog4[k], acq + k * conv);
    end
    tot8 = len8 * 16; tot4 = len4 * 16;
    nb = ((tot8 > tot4) ? tot8 : tot4) + 16;
    for (int i = 0; i < nb; i++) begin
      logic [15:0] w8, w4;
      logic e8, e4;
      w8 = word8((i % tot8) / 16); e8 = w8[15 - (i % 16)];
      w4 = word4((i % tot4) / 16); e4 = w4[15 - (i % 16)];
      chk(dout8 == e8, (i >= tot8) ? "R10" : "R9", "dut8 dout bit", int'(dout8), int'(e8));
      chk(dout4 == e4, (i >= tot4) ? "R10" : "R9", "dut4 dout bit", int'(dout4), int'(e4));
      sclk = 1; @(negedge clk);
      sclk = 0; @(negedge clk);
    end
  endtask

  initial begin
    int held;
    logic ok;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(eocN8 && eocN4, "R8", "eocN high after reset", int'(eocN8 & eocN4), 1);
    chk(!dout8 && !dout4, "R13", "dout low after reset", int'(dout8 | dout4), 0);
    chk(!sampleStb8, "R6", "no sample strobe after reset", int'(sampleStb8), 0);
    csN = 0;
    @(negedge clk);
    chk(!dout8 && eocN8, "R13", "dout low while idle and selected", int'(dout8), 0);

    for (int v = 0; v < 7; v++) runVec(VEC[v]);

    // R11: abort mid-sequence
    issue({2'b01, 3'd7, 1'b1, 1'b1});
    for (int c = 0; c < 2000; c++) begin
      @(posedge clk);
      if (n8 >= 2) break;
    end
    held = n8;
    @(negedge clk); csN = 1;
    repeat (400) @(negedge clk);
    chk(n8 == held, "R11", "no sample strobe after abort", n8, held);
    chk(eocN8 == 1, "R11", "eocN stays high after abort", int'(eocN8), 1);
    chk(dout8 == 0, "R13", "dout low after abort", int'(dout8), 0);
    csN = 0;
    @(negedge clk);

    // R12: eocN returns high on chip-select rise after completion
    issue({2'b00, 3'd1, 1'b1, 1'b0});
    waitDone(ok);
    chk(ok && !eocN8, "R8", "single conversion completes", int'(eocN8), 0);
    csN = 1;
    @(negedge clk);
    chk(eocN8 && eocN4, "R12", "eocN high after csN rise", int'(eocN8 & eocN4), 1);
    chk(!dout8 && !dout4, "R13", "dout low after csN rise", int'(dout8 | dout4), 0);
    csN = 0;
    @(negedge clk);

    // R12: new command while results are being held
    issue({2'b00, 3'd2, 1'b1, 1'b0});
    waitDone(ok);
    issue({2'b00, 3'd4, 1'b1, 1'b0});
    chk(!dout8, "R13", "dout low once new command runs", int'(dout8), 0);
    waitDone(ok);
    chk(ok && chLog8[0] == 4, "R1", "restarted single channel", chLog8[0], 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule